// File: doc/BRIEF.md
# Stepped Soft-Start Current-Limit Sequencer

This block sits beside the switch current-limit comparators of a group of step-down converters and linear regulators. For each converter it picks the peak switch current limit during start-up. The limit begins at the lowest level and is raised one rung at a time by a shared step-tick strobe until the full limit is reached. A single supply-OK flag comes from an input undervoltage comparator whose hysteresis is analog. That flag qualifies every regulator enable: while the supply is low, every regulator is held off and every soft-start run is abandoned.

A converter starts only when its enable goes from low to high while the supply is already good. If the enable was high before the supply came up, the converter stays off until the enable is toggled. The linear-regulator enables have no soft start. They follow their pins whenever the supply is good. Channel indices `0 .. N_CONV-1` of the enable vector are converters, and the remaining indices are linear regulators.

Top module: `softstart_limit_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all `reg_en` bits and all `ss_active` bits are 0 and every limit code is 0. An enable pin that is already high during reset counts as previously high, so it does not start a converter.
- R2: The limit code of a converter has four values: 0 for 250 mA, 1 for 500 mA, 2 for 950 mA and 3 for the full 2 A. Converter `i` uses bits `ilim_code[2*i+1:2*i]`. While soft start is active, each clock edge that samples `step_tick` high raises the code by exactly one, and the new code is visible after that edge.
- R3: When the code reaches 3, `ss_active` clears on the same edge. Later ticks leave the code at 3.
- R4: After any edge that samples `vin_ok` low, all `reg_en` bits are 0.
- R5: While `vin_ok` is high, each linear-regulator bit of `reg_en` equals its enable pin as sampled at the previous edge.
- R6: An edge that samples a converter pin high, while that pin was low at the previous edge and `vin_ok` is high, starts soft start. After that edge `reg_en[i]` is 1, `ss_active[i]` is 1 and the code is 0. A tick sampled on that same edge does not advance the code.
- R7: An edge that samples a converter pin low, or `vin_ok` low, returns that converter to code 0 with `ss_active` 0 and `reg_en` 0. This also aborts a soft start that is in progress.
- R8: If a converter pin is already high when `vin_ok` rises, the converter stays off: `reg_en` 0, `ss_active` 0 and code 0, whatever ticks arrive. This holds until the pin goes low and high again.
- R9: Converter channels are independent. One channel's pin, ramp or abort does not change another channel's code, `ss_active` or `reg_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_ok | input | 1 | Input-supply-good flag from the undervoltage comparator |
| step_tick | input | 1 | One-cycle strobe that advances active soft-start ramps |
| en_pin | input | N_CONV+N_LDO | Regulator enable requests; low indices are converters |
| ilim_code | output | 2*N_CONV | Current-limit code per converter, 2 bits each |
| ss_active | output | N_CONV | Soft start in progress, per converter |
| reg_en | output | N_CONV+N_LDO | Qualified regulator enables |

## Verification
Every result of this block comes from registers and is due exactly one clock edge after the stimulus is sampled. This covers a start, a tick step, an abort, a gating change and a linear-regulator follow. The bench changes its inputs on the falling edge and compares the outputs on the next falling edge, which is half a period after the single rising edge that produces them. Ticks are held high for exactly one rising edge. The boundary cases each get their own scenario: a tick coinciding with the start edge, a tick at the full level, a pin high before the supply comes up, and an abort in mid-ramp.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    typedef logic [1:0] ilim_code_t;

    localparam ilim_code_t ILIM_250MA = 2'd0;
    localparam ilim_code_t ILIM_500MA = 2'd1;
    localparam ilim_code_t ILIM_950MA = 2'd2;
    localparam ilim_code_t ILIM_FULL  = 2'd3;

    localparam int unsigned CODE_W = $bits(ilim_code_t);

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_RAMP,
        CH_FULL
    } ch_state_e;

    typedef struct packed {
        ch_state_e  st;
        ilim_code_t code;
    } ch_reg_t;

    localparam ch_reg_t CH_RESET = '{st: CH_IDLE, code: ILIM_250MA};

    function automatic ilim_code_t ladder_next(input ilim_code_t c);
        return (c == ILIM_FULL) ? ILIM_FULL : ilim_code_t'(c + 2'd1);
    endfunction

endpackage

// File: rtl/ss_channel.sv
module ss_channel
    import ss_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vin_ok,
    input  logic       en_pin,
    input  logic       step_tick,
    output ilim_code_t ilim_code,
    output logic       ss_active,
    output logic       conv_en
);

    logic    en_q;
    ch_reg_t r_q, r_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b1;
            r_q  <= CH_RESET;
        end else begin
            en_q <= en_pin;
            r_q  <= r_nx;
        end
    end

    always_comb begin
        r_nx = r_q;
        if (!en_pin || !vin_ok) begin
            r_nx = CH_RESET;
        end else begin
            case (r_q.st)
                CH_IDLE: begin
                    if (!en_q) r_nx = '{st: CH_RAMP, code: ILIM_250MA};
                end
                CH_RAMP: begin
                    if (step_tick) begin
                        r_nx.code = ladder_next(r_q.code);
                        if (r_nx.code == ILIM_FULL) r_nx.st = CH_FULL;
                    end
                end
                default: ;
            endcase
        end
    end

    assign ilim_code = r_q.code;
    assign ss_active = (r_q.st == CH_RAMP);
    assign conv_en   = (r_q.st != CH_IDLE);

    // R2: the code moves only by a single rung upward or back to the bottom
    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
        (r_q.code != $past(r_q.code)) |->
            ((r_q.code == ilim_code_t'($past(r_q.code) + 2'd1)) || (r_q.code == ILIM_250MA)));

    // R3: once full, the code stays full and soft start stays cleared while enabled
    p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == CH_FULL && en_pin && vin_ok) |=> (r_q.code == ILIM_FULL && !ss_active));

    // R7: losing the pin or the supply aborts the channel
    p_abort_r7: assert property (@(posedge clk) disable iff (rst)
        (!en_pin || !vin_ok) |=> (r_q.code == ILIM_250MA && !ss_active && !conv_en));

    // R8: a supply arriving under an already-high pin does not start the converter
    p_late_supply_r8: assert property (@(posedge clk) disable iff (rst)
        (vin_ok && !$past(vin_ok) && en_pin && $past(en_pin)) |=> !conv_en);

endmodule

// File: rtl/ss_ldo_gate.sv
module ss_ldo_gate #(
    parameter int unsigned N_LDO = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vin_ok,
    input  logic [N_LDO-1:0] en_pin,
    output logic [N_LDO-1:0] ldo_en
);

    always_ff @(posedge clk) begin
        if (rst) ldo_en <= '0;
        else     ldo_en <= vin_ok ? en_pin : '0;
    end

    // R5: with the supply good, each enable tracks its pin one edge later
    p_ldo_follow_r5: assert property (@(posedge clk) disable iff (rst)
        vin_ok |=> (ldo_en == $past(en_pin)));

endmodule

// File: rtl/softstart_limit_seq.sv
module softstart_limit_seq
    import ss_seq_pkg::*;
#(
    parameter int unsigned N_CONV = 2,
    parameter int unsigned N_LDO  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       vin_ok,
    input  logic                       step_tick,
    input  logic [N_CONV+N_LDO-1:0]    en_pin,
    output logic [N_CONV*CODE_W-1:0]   ilim_code,
    output logic [N_CONV-1:0]          ss_active,
    output logic [N_CONV+N_LDO-1:0]    reg_en
);

    localparam int unsigned N_REG = N_CONV + N_LDO;

    logic [N_CONV-1:0] conv_en;
    logic [N_LDO-1:0]  ldo_en;

    for (genvar i = 0; i < N_CONV; i++) begin : g_conv
        ss_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .vin_ok    (vin_ok),
            .en_pin    (en_pin[i]),
            .step_tick (step_tick),
            .ilim_code (ilim_code[i*CODE_W +: CODE_W]),
            .ss_active (ss_active[i]),
            .conv_en   (conv_en[i])
        );
    end

    ss_ldo_gate #(.N_LDO(N_LDO)) u_ldo (
        .clk    (clk),
        .rst    (rst),
        .vin_ok (vin_ok),
        .en_pin (en_pin[N_REG-1:N_CONV]),
        .ldo_en (ldo_en)
    );

    assign reg_en = {ldo_en, conv_en};

    // R4: a low supply turns every regulator off at the next edge
    p_uvlo_off_r4: assert property (@(posedge clk) disable iff (rst)
        !vin_ok |=> (reg_en == '0));

    // R1: nothing is on in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (reg_en == '0 && ss_active == '0 && ilim_code == '0));

endmodule

// File: tb/softstart_limit_seq_tb.sv
module softstart_limit_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vin_ok = 1'b0;
    logic       step_tick = 1'b0;
    logic [3:0] en_pin = 4'b0000;
    logic [3:0] ilim_code;
    logic [1:0] ss_active;
    logic [3:0] reg_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    softstart_limit_seq u_dut (
        .clk       (clk),
        .rst       (rst),
        .vin_ok    (vin_ok),
        .step_tick (step_tick),
        .en_pin    (en_pin),
        .ilim_code (ilim_code),
        .ss_active (ss_active),
        .reg_en    (reg_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int code_of(input int ch);
        return int'(ilim_code[2*ch +: 2]);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; vin_ok = 1'b1; en_pin = 4'b1111; step_tick = 1'b1;
        cyc();
        check("R1 reg_en in reset", int'(reg_en), 0);
        check("R1 ss_active in reset", int'(ss_active), 0);
        check("R1 codes in reset", int'(ilim_code), 0);
        rst = 1'b0; step_tick = 1'b0;
        cyc();
        check("R1 converters idle after reset with pins high", int'(reg_en[1:0]), 0);
        check("R1 no soft start after reset", int'(ss_active), 0);
        en_pin = 4'b0000;
        cyc();
        check("R5 ldo off after pins low", int'(reg_en), 0);
    endtask

    task automatic t_ramp();
        en_pin[0] = 1'b1;
        cyc();
        check("R6 ch0 enabled on edge", int'(reg_en[0]), 1);
        check("R6 ch0 ss active", int'(ss_active[0]), 1);
        check("R6 ch0 code starts 250mA", code_of(0), 0);
        check("R9 ch1 untouched", int'({reg_en[1], ss_active[1]}), 0);
        cyc();
        check("R2 code holds without tick", code_of(0), 0);
        for (int k = 1; k <= 3; k++) begin
            step_tick = 1'b1;
            cyc();
            step_tick = 1'b0;
            check("R2 ch0 ladder step", code_of(0), k);
            check("R3 ss_active until full", int'(ss_active[0]), (k < 3) ? 1 : 0);
            check("R9 ch1 code stays 0", code_of(1), 0);
        end
        step_tick = 1'b1;
        cyc();
        step_tick = 1'b0;
        check("R3 code saturates at full", code_of(0), 3);
        check("R3 ss stays clear", int'(ss_active[0]), 0);
        check("R3 converter stays on", int'(reg_en[0]), 1);
    endtask

    task automatic t_edge_tick();
        en_pin[1] = 1'b1; step_tick = 1'b1;
        cyc();
        step_tick = 1'b0;
        check("R6 tick on start edge ignored", code_of(1), 0);
        check("R6 ch1 ss active", int'(ss_active[1]), 1);
        check("R6 ch1 enabled", int'(reg_en[1]), 1);
    endtask

    task automatic t_abort();
        step_tick = 1'b1;
        cyc();
        step_tick = 1'b0;
        check("R2 ch1 first step", code_of(1), 1);
        en_pin[1] = 1'b0;
        cyc();
        check("R7 abort code", code_of(1), 0);
        check("R7 abort ss", int'(ss_active[1]), 0);
        check("R7 abort enable", int'(reg_en[1]), 0);
        check("R9 ch0 still full", code_of(0), 3);
    endtask

    task automatic t_ldo();
        en_pin[2] = 1'b1;
        cyc();
        check("R5 ldo2 follows", int'(reg_en[3:2]), 1);
        en_pin[3:2] = 2'b10;
        cyc();
        check("R5 ldo swap", int'(reg_en[3:2]), 2);
    endtask

    task automatic t_uvlo();
        en_pin = 4'b1111; vin_ok = 1'b0;
        cyc();
        check("R4 all off on low supply", int'(reg_en), 0);
        check("R7 ch0 code reset by supply loss", code_of(0), 0);
        check("R7 ss cleared by supply loss", int'(ss_active), 0);
        vin_ok = 1'b1;
        cyc();
        check("R5 ldos back on", int'(reg_en[3:2]), 3);
        check("R8 converters stay off", int'(reg_en[1:0]), 0);
        check("R8 no soft start", int'(ss_active), 0);
        step_tick = 1'b1;
        cyc();
        step_tick = 1'b0;
        check("R8 tick ignored while blocked", int'(ilim_code), 0);
        check("R8 still off", int'(reg_en[1:0]), 0);
        en_pin[0] = 1'b0;
        cyc();
        en_pin[0] = 1'b1;
        cyc();
        check("R8 toggle restarts ch0", int'(reg_en[0]), 1);
        check("R8 ch0 ss active after toggle", int'(ss_active[0]), 1);
        check("R9 ch1 still blocked", int'(reg_en[1]), 0);
    endtask

    initial begin
        t_reset();
        vin_ok = 1'b1;
        cyc();
        t_ramp();
        t_edge_tick();
        t_abort();
        t_ldo();
        t_uvlo();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule